// File: doc/BRIEF.md
# Thermal Alarm Comparator with Fault Queue

This block sets an over-temperature alarm pin from a stream of converted temperature samples. Each accepted sample is compared against a trip limit and a hysteresis limit. The alarm changes state only after a programmable number of consecutive samples have all met the condition being watched. Samples are 11-bit two's complement values. Only their upper nine bits take part in the comparison, so the resolution matches the 9-bit limits. The limits and a 5-bit configuration word come from register storage outside the block. A one-cycle pulse tells the block that software has read any register.

There are two ways of working. In thermostat (comparator) mode, the alarm turns on above the trip limit and turns off below the hysteresis limit. Register reads and shutdown leave it alone. In latched interrupt mode, the alarm records one event and holds it until a register read clears it. The events alternate: first a trip crossing, then a hysteresis crossing, and so on. Entering shutdown also clears a held event. A configuration bit sets whether the alarm pin is active high or active low. For the neighbouring register block, the package also provides reset values for the limits: 80 °C and 75 °C, which are 9'h0A0 and 9'h096 at 0.5 °C per LSB.

Top module: `thermal_alarm`

## Requirements
- R1: Only sample bits [10:2] are compared, as signed 9-bit values. The trip condition is sample strictly greater than the trip limit. The hysteresis condition is sample strictly less than the hysteresis limit. Sample bits [1:0] have no effect.
- R2: A sample is evaluated only when `sample_valid` is high and configuration bit 0 (shutdown) is clear. Samples presented during shutdown never change the alarm.
- R3: In comparator mode (configuration bit 1 clear), an inactive alarm becomes active after the queue count of consecutive trip-condition samples. An active alarm becomes inactive after the queue count of consecutive hysteresis-condition samples.
- R4: In comparator mode, a `reg_read` pulse or shutdown leaves the alarm state unchanged.
- R5: In interrupt mode (configuration bit 1 set), the first event after reset is the trip condition. Hysteresis-condition samples before it raise nothing. A raised alarm stays active until a `reg_read` pulse clears it.
- R6: In interrupt mode, after a trip event has been cleared, the next event is the hysteresis condition. After that one is cleared, the next event is the trip condition again, and the pattern repeats.
- R7: In interrupt mode, shutdown clears an active alarm.
- R8: Configuration bits [4:3] set the queue count: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 6 consecutive samples. An evaluated sample that does not meet the watched condition restarts the count from zero.
- R9: When configuration bit 2 is set, the pin is high while the alarm is active. When bit 2 is clear, the pin is low while active. After reset the alarm is inactive.
- R10: The alarm takes its new state at the clock edge that accepts the deciding sample. The pin shows it from that edge on, and not before.
- R11: In interrupt mode, samples that arrive while an alarm is held do not count toward the next event. Counting starts afresh after the read that clears the alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | Strobe marking a finished conversion |
| sample | input | 11 | Two's complement temperature sample |
| trip_lim | input | 9 | Two's complement trip limit, 0.5 °C per LSB |
| hyst_lim | input | 9 | Two's complement hysteresis limit, 0.5 °C per LSB |
| cfg | input | 5 | [0] shutdown, [1] interrupt mode, [2] active-high pin, [4:3] queue code |
| reg_read | input | 1 | One-cycle pulse for any register read |
| alarm_pin | output | 1 | Alarm output at the selected polarity |

## Verification
The bench builds the block with its default widths: an 11-bit sample against 9-bit limits. At these widths, dropping exactly two fraction bits can be shown directly, and a 3-bit counter can reach the deepest queue setting of six samples. Limits below zero, set against positive samples, expose any unsigned comparison. The interrupt scenarios begin from a fresh reset, so the trip-first order and the trip/hysteresis alternation are observed from a known start.

// File: rtl/tac_pkg.sv
package tac_pkg;

    // Bit positions inside the configuration word.
    localparam int CFG_W      = 5;
    localparam int CFG_SHDN   = 0;
    localparam int CFG_INTR   = 1;
    localparam int CFG_POL    = 2;
    localparam int CFG_FQ_LO  = 3;
    localparam int FQ_W       = 2;

    // Reset values for the neighbouring limit registers (0.5 C per LSB).
    localparam logic [8:0] TRIP_RESET = 9'h0A0;
    localparam logic [8:0] HYST_RESET = 9'h096;

    // Widest queue count and the counter width it needs.
    localparam int FQ_MAX = 6;
    localparam int CNT_W  = $clog2(FQ_MAX + 1);

    function automatic logic [CNT_W-1:0] fq_depth(input logic [FQ_W-1:0] code);
        logic [CNT_W-1:0] d;
        case (code)
            2'b00:   d = CNT_W'(1);
            2'b01:   d = CNT_W'(2);
            2'b10:   d = CNT_W'(4);
            default: d = CNT_W'(FQ_MAX);
        endcase
        return d;
    endfunction

    typedef struct packed {
        logic alarm;      // alarm active (polarity-free)
        logic want_trip;  // interrupt mode: next event is the trip crossing
    } alarm_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } fq_st_t;

endpackage

// File: rtl/tac_compare.sv
module tac_compare #(
    parameter int TEMP_W = 11,
    parameter int LIM_W  = 9
) (
    input  logic [TEMP_W-1:0] sample,
    input  logic [LIM_W-1:0]  trip_lim,
    input  logic [LIM_W-1:0]  hyst_lim,
    output logic              over_trip,
    output logic              under_hyst
);
    localparam int DROP = TEMP_W - LIM_W;

    logic [LIM_W-1:0] t_top;

    generate
        if (DROP > 0) begin : g_trunc
            assign t_top = sample[TEMP_W-1 -: LIM_W];
        end else begin : g_same
            assign t_top = sample[LIM_W-1:0];
        end
    endgenerate

    always_comb begin
        over_trip  = $signed(t_top) > $signed(trip_lim);
        under_hyst = $signed(t_top) < $signed(hyst_lim);
    end

endmodule

// File: rtl/tac_fault_count.sv
module tac_fault_count
    import tac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            hit,
    input  logic            flush,
    input  logic [FQ_W-1:0] depth_code,
    output logic            fire
);
    fq_st_t st_q, st_d;

    logic [CNT_W-1:0] depth;
    logic [CNT_W:0]   next_cnt;

    always_comb begin
        depth    = fq_depth(depth_code);
        next_cnt = {1'b0, st_q.cnt} + 1'b1;
        fire     = 1'b0;
        st_d     = st_q;
        if (flush) begin
            st_d.cnt = '0;
        end else if (step) begin
            if (!hit) begin
                st_d.cnt = '0;
            end else if (next_cnt >= {1'b0, depth}) begin
                fire     = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = next_cnt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tac_alarm_state.sv
module tac_alarm_state
    import tac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic intr_mode,
    input  logic shutdown,
    input  logic reg_read,
    output logic alarm,
    output logic watch_trip
);
    alarm_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (intr_mode) begin
            if (fire) begin
                st_d.alarm     = 1'b1;
                st_d.want_trip = ~st_q.want_trip;
            end else if (shutdown || reg_read) begin
                st_d.alarm = 1'b0;
            end
        end else if (fire) begin
            st_d.alarm = ~st_q.alarm;
        end
        alarm      = st_q.alarm;
        watch_trip = intr_mode ? st_q.want_trip : ~st_q.alarm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.alarm     <= 1'b0;
            st_q.want_trip <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/thermal_alarm.sv
module thermal_alarm
    import tac_pkg::*;
#(
    parameter int TEMP_W = 11,
    parameter int LIM_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] sample,
    input  logic [LIM_W-1:0]  trip_lim,
    input  logic [LIM_W-1:0]  hyst_lim,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              reg_read,
    output logic              alarm_pin
);
    logic over_trip, under_hyst;
    logic alarm_act, watch_trip;
    logic step, hit, flush, fire;

    tac_compare #(.TEMP_W(TEMP_W), .LIM_W(LIM_W)) u_cmp (
        .sample     (sample),
        .trip_lim   (trip_lim),
        .hyst_lim   (hyst_lim),
        .over_trip  (over_trip),
        .under_hyst (under_hyst)
    );

    always_comb begin
        flush = cfg[CFG_INTR] & alarm_act;
        step  = sample_valid & ~cfg[CFG_SHDN] & ~flush;
        hit   = watch_trip ? over_trip : under_hyst;
    end

    tac_fault_count u_fq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .hit        (hit),
        .flush      (flush),
        .depth_code (cfg[CFG_FQ_LO +: FQ_W]),
        .fire       (fire)
    );

    tac_alarm_state u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .intr_mode  (cfg[CFG_INTR]),
        .shutdown   (cfg[CFG_SHDN]),
        .reg_read   (reg_read),
        .alarm      (alarm_act),
        .watch_trip (watch_trip)
    );

    assign alarm_pin = cfg[CFG_POL] ? alarm_act : ~alarm_act;

endmodule

// File: rtl/thermal_alarm_chk.sv
module thermal_alarm_chk
    import tac_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic [CFG_W-1:0] cfg,
    input logic             reg_read,
    input logic             alarm_act
);
    assert_cmp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[CFG_INTR] && !sample_valid) |=> $stable(alarm_act));

    assert_rise_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_act) |-> $past(sample_valid && !cfg[CFG_SHDN]));

    assert_intr_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[CFG_INTR] && alarm_act && !reg_read && !cfg[CFG_SHDN]) |=> alarm_act);

    assert_intr_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[CFG_INTR] && reg_read && !sample_valid) |=> !alarm_act);

    assert_intr_shdn_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[CFG_INTR] && cfg[CFG_SHDN]) |=> !alarm_act);

endmodule

bind thermal_alarm thermal_alarm_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .cfg          (cfg),
    .reg_read     (reg_read),
    .alarm_act    (alarm_act)
);

// File: tb/thermal_alarm_tb.sv
module thermal_alarm_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [10:0] sample = '0;
    logic [8:0]  trip_lim = 9'h0A0;
    logic [8:0]  hyst_lim = 9'h096;
    logic [4:0]  cfg = 5'b00000;
    logic        reg_read = 1'b0;
    logic        alarm_pin;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    thermal_alarm u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_valid (sample_valid),
        .sample       (sample),
        .trip_lim     (trip_lim),
        .hyst_lim     (hyst_lim),
        .cfg          (cfg),
        .reg_read     (reg_read),
        .alarm_pin    (alarm_pin)
    );

    function automatic logic pin_for(input logic active);
        return cfg[2] ? active : ~active;
    endfunction

    task automatic check(input string req, input logic active);
        logic exp;
        exp = pin_for(active);
        checks++;
        if (alarm_pin !== exp) begin
            errs++;
            $display("FAIL %s: alarm_pin=%b expected %b", req, alarm_pin, exp);
        end
    endtask

    task automatic put(input logic [8:0] t, input logic [1:0] frac = 2'b00);
        @(negedge clk);
        sample       = {t, frac};
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic pulse_read;
        @(negedge clk);
        reg_read = 1'b1;
        @(negedge clk);
        reg_read = 1'b0;
    endtask

    task automatic set_cfg(input logic [4:0] v);
        @(negedge clk);
        cfg = v;
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n        = 1'b0;
        sample_valid = 1'b0;
        reg_read     = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        cfg = 5'b00000;
        do_reset();
        check("R9 reset inactive, active-low pin high", 1'b0);
    endtask

    task automatic t_compare;
        trip_lim = 9'h0A0; hyst_lim = 9'h096;
        put(9'h0A0);        check("R1 equal to trip does not trip", 1'b0);
        put(9'h0A0, 2'b11); check("R1 low bits ignored", 1'b0);
        put(9'h0A1);        check("R3 above trip activates", 1'b1);
        put(9'h097);        check("R3 between limits holds", 1'b1);
        put(9'h096);        check("R1 equal to hyst does not clear", 1'b1);
        put(9'h095, 2'b11); check("R3 below hyst clears", 1'b0);
    endtask

    task automatic t_signed;
        trip_lim = 9'h1F0; hyst_lim = 9'h1E0;
        put(9'h1EE); check("R1 signed below negative trip", 1'b0);
        put(9'h001); check("R1 positive above negative trip", 1'b1);
        put(9'h1E1); check("R1 signed above negative hyst", 1'b1);
        put(9'h1DF); check("R1 signed below negative hyst", 1'b0);
        trip_lim = 9'h0A0; hyst_lim = 9'h096;
    endtask

    task automatic t_latency;
        @(negedge clk);
        sample = {9'h0A1, 2'b00};
        sample_valid = 1'b1;
        check("R10 no change before accepting edge", 1'b0);
        @(negedge clk);
        sample_valid = 1'b0;
        check("R10 change right after accepting edge", 1'b1);
        put(9'h080); check("R10 cleared", 1'b0);
    endtask

    task automatic t_cmp_hold;
        put(9'h0A1);  check("R3 setup active", 1'b1);
        pulse_read(); check("R4 read keeps comparator alarm", 1'b1);
        set_cfg(5'b00001); check("R4 shutdown keeps comparator alarm", 1'b1);
        put(9'h080);  check("R2 sample ignored in shutdown", 1'b1);
        set_cfg(5'b00000);
        put(9'h080);  check("R2 sample used after shutdown", 1'b0);
        set_cfg(5'b00001);
        put(9'h0A5);  check("R2 hot sample ignored in shutdown", 1'b0);
        set_cfg(5'b00000);
    endtask

    task automatic t_queue;
        set_cfg(5'b10000);
        for (int i = 0; i < 3; i++) put(9'h0A1);
        check("R8 code 10 three hits not enough", 1'b0);
        put(9'h0A0);
        for (int i = 0; i < 3; i++) put(9'h0A1);
        check("R8 miss restarts count", 1'b0);
        put(9'h0A1); check("R8 code 10 fourth hit activates", 1'b1);
        set_cfg(5'b11000);
        for (int i = 0; i < 5; i++) put(9'h090);
        check("R8 code 11 five hits not enough", 1'b1);
        put(9'h090); check("R8 code 11 sixth hit clears", 1'b0);
        set_cfg(5'b01000);
        put(9'h0A1); check("R8 code 01 one hit not enough", 1'b0);
        put(9'h0A1); check("R8 code 01 second hit activates", 1'b1);
        put(9'h090); put(9'h097); put(9'h090);
        check("R8 miss between hysteresis hits restarts", 1'b1);
        put(9'h090); check("R8 two hysteresis hits clear", 1'b0);
        set_cfg(5'b00000);
    endtask

    task automatic t_polarity;
        set_cfg(5'b00100); check("R9 active-high inactive low", 1'b0);
        put(9'h0A1);       check("R9 active-high active high", 1'b1);
        put(9'h090);       check("R9 active-high back low", 1'b0);
        set_cfg(5'b00000);
    endtask

    task automatic t_intr;
        cfg = 5'b00010;
        do_reset();
        put(9'h090);  check("R5 hysteresis first raises nothing", 1'b0);
        put(9'h0A1);  check("R5 trip event raises alarm", 1'b1);
        put(9'h090);  check("R5 alarm held until read", 1'b1);
        pulse_read(); check("R5 read clears", 1'b0);
        put(9'h0A5);  check("R6 trip ignored after trip event", 1'b0);
        put(9'h090);  check("R6 hysteresis event raises", 1'b1);
        pulse_read(); check("R6 read clears hysteresis event", 1'b0);
        put(9'h090);  check("R6 hysteresis ignored after hysteresis event", 1'b0);
        put(9'h0A5);  check("R6 trip event again", 1'b1);
        set_cfg(5'b00011); check("R7 shutdown clears interrupt alarm", 1'b0);
        put(9'h090);  check("R2 interrupt sample ignored in shutdown", 1'b0);
        set_cfg(5'b00010);
    endtask

    task automatic t_pending;
        cfg = 5'b01010;
        do_reset();
        put(9'h0A1); put(9'h0A1); check("R11 trip after two hits", 1'b1);
        put(9'h090); put(9'h090);
        pulse_read(); check("R11 cleared by read", 1'b0);
        put(9'h090); check("R11 held samples did not count", 1'b0);
        put(9'h090); check("R11 counting after read", 1'b1);
    endtask

    initial begin
        t_reset();
        t_compare();
        t_signed();
        t_latency();
        t_cmp_hold();
        t_queue();
        t_polarity();
        t_intr();
        t_pending();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: run not finished, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule